// File: doc/BRIEF.md
# Prefixed Serial Register Access Engine

This block performs single-register writes and reads on a display controller. The controller's serial link expects a one-byte control prefix ahead of every transfer. A parallel command port takes an operation, a register address and a write byte, plus a start strobe. The engine then produces the chip-select, serial-clock and serial-out pin waveforms itself, and it samples the panel's serial-in line.

A write is sent as two separate chip-select frames. The first frame carries the register address behind the index prefix. The second frame carries the value behind the data prefix. A read is a single frame: the read prefix goes out, then sixteen more clocks sample the panel's reply, most significant bit first. The captured word is returned with a one-cycle valid pulse. Every bit lasts two half-periods of `HALF_DIV` system cycles each. The serial clock is low in the first half and high in the second, so the rising edge falls in the middle of the bit.

Top module: `pfx_reg_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, serial out is high, busy is low and read-valid is low.
- R2: With op = 0 (write), the first frame holds 16 bits, MSB first, sampled on clock rises: 0x70 followed by the 8-bit address.
- R3: The second frame of a write holds 16 bits, MSB first: 0x72 followed by the 8-bit write value.
- R4: Between the two frames of a write, chip select stays high for at least one full bit period (2*HALF_DIV cycles).
- R5: With op = 1 (read), the single frame holds 24 clock rises. Serial out carries 0x73 MSB first on the first 8, and is held high during the remaining 16.
- R6: During a read, the panel input is sampled at the end of the clock-high half of each of the last 16 bits. The first sampled bit becomes bit 15 of the returned word.
- R7: The read-valid output pulses for exactly one cycle, one cycle after chip select rises at the end of a read, together with the captured word. A write produces no pulse.
- R8: Serial out changes only while the serial clock is low, and the serial clock is low whenever chip select is high.
- R9: At the end of any transaction, chip select and serial out are left high and the clock is left low.
- R10: Busy is high from the cycle after an accepted start until the transaction completes. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe, accepted while idle |
| cmd_op | input | 1 | 0 = register write, 1 = register read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write value |
| cmd_busy | output | 1 | Transaction in progress |
| rsp_data | output | 16 | Word returned by a read |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_data |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| pnl_sclk | output | 1 | Panel serial clock |
| pnl_sdo | output | 1 | Serial data to the panel |
| pnl_sdi | input | 1 | Serial data from the panel |

## Verification
Writes are swept over all 256 addresses, each paired with a different value. This separates the address byte from the value byte and shows any swapped, shifted or mis-prefixed frame. Reads return walking-one and walking-zero words plus all-zero, all-one and mixed words. These expose a bit-order reversal, an off-by-one sampling point or a stuck bit in the captured word. A start strobe issued in the middle of a write shows whether a busy engine wrongly accepts a second command.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam logic [7:0] PFX_INDEX = 8'h70;
  localparam logic [7:0] PFX_DATA  = 8'h72;
  localparam logic [7:0] PFX_READ  = 8'h73;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_GAP, S_DONE
  } seq_state_t;
endpackage

// File: rtl/pfx_tick.sv
module pfx_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_pkg::*;
#(
  parameter int PFX_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int WDATA_W    = 8,
  parameter int RDATA_W    = 16,
  parameter int GAP_HALVES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic               run,
  input  logic               start,
  input  logic               op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WDATA_W-1:0] wdata,
  output logic               busy,
  output logic [RDATA_W-1:0] rd_data,
  output logic               rd_valid,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdo,
  input  logic               sdi
);
  localparam int FRM_W  = PFX_W + RDATA_W;
  localparam int IDX_LEN = PFX_W + ADDR_W;
  localparam int DAT_LEN = PFX_W + WDATA_W;
  localparam int BW     = $clog2(FRM_W + 1);
  localparam int GW     = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
  localparam logic [BW-1:0] RD_LAST  = BW'(FRM_W - 1);
  localparam logic [BW-1:0] IDX_LAST = BW'(IDX_LEN - 1);
  localparam logic [BW-1:0] DAT_LAST = BW'(DAT_LEN - 1);
  localparam logic [BW-1:0] RX_FROM  = BW'(PFX_W);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_HALVES - 1);

  seq_state_t         state;
  logic [FRM_W-1:0]   shreg;
  logic [BW-1:0]      bcnt;
  logic [BW-1:0]      blast;
  logic [GW-1:0]      gcnt;
  logic               is_rd;
  logic               wr_pend;
  logic [WDATA_W-1:0] hold;
  logic [RDATA_W-1:0] rx;

  assign run = (state == S_LOW) || (state == S_HIGH) || (state == S_GAP);
  assign sdo = shreg[FRM_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      shreg    <= '1;
      bcnt     <= '0;
      blast    <= '0;
      gcnt     <= '0;
      is_rd    <= 1'b0;
      wr_pend  <= 1'b0;
      hold     <= '0;
      rx       <= '0;
      busy     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          busy  <= 1'b1;
          cs_n  <= 1'b0;
          bcnt  <= '0;
          state <= S_LOW;
          hold  <= wdata;
          if (op == OP_READ) begin
            is_rd   <= 1'b1;
            wr_pend <= 1'b0;
            blast   <= RD_LAST;
            shreg   <= {PFX_READ, {RDATA_W{1'b1}}};
          end else begin
            is_rd   <= 1'b0;
            wr_pend <= 1'b1;
            blast   <= IDX_LAST;
            shreg   <= {PFX_INDEX, addr, {(FRM_W-IDX_LEN){1'b1}}};
          end
        end
        S_LOW: if (tick) begin
          sclk  <= 1'b1;
          state <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (is_rd && bcnt >= RX_FROM) rx <= {rx[RDATA_W-2:0], sdi};
          if (bcnt == blast) begin
            cs_n  <= 1'b1;
            shreg <= '1;
            gcnt  <= '0;
            state <= wr_pend ? S_GAP : S_DONE;
          end else begin
            shreg <= {shreg[FRM_W-2:0], 1'b1};
            bcnt  <= bcnt + 1'b1;
            state <= S_LOW;
          end
        end
        S_GAP: if (tick) begin
          if (gcnt == GAP_LAST) begin
            cs_n    <= 1'b0;
            bcnt    <= '0;
            blast   <= DAT_LAST;
            wr_pend <= 1'b0;
            shreg   <= {PFX_DATA, hold, {(FRM_W-DAT_LEN){1'b1}}};
            state   <= S_LOW;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_DONE: begin
          busy  <= 1'b0;
          state <= S_IDLE;
          if (is_rd) begin
            rd_valid <= 1'b1;
            rd_data  <= rx;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Serial out may only move while the clock is low
  assert_sdo_moves_low_R8: assert property (@(posedge clk) disable iff (rst)
    (sdo != $past(sdo)) |-> !sclk);

  // Clock is parked low whenever the panel is deselected
  assert_sclk_parked_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // Read reply phase keeps serial out high
  assert_rd_sdo_high_R5: assert property (@(posedge clk) disable iff (rst)
    (is_rd && !cs_n && bcnt >= RX_FROM) |-> sdo);

  // Read-valid follows a chip-select release by exactly one cycle
  assert_valid_after_cs_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // Idle engine leaves the link parked
  assert_idle_parked_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && sdo && !sclk));

  // A start while busy must not restart the frame counter
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state == S_HIGH && !tick) |=> (bcnt == $past(bcnt)));
endmodule

// File: rtl/pfx_reg_engine.sv
module pfx_reg_engine #(
  parameter int HALF_DIV   = 2,
  parameter int ADDR_W     = 8,
  parameter int WDATA_W    = 8,
  parameter int RDATA_W    = 16,
  parameter int GAP_HALVES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_start,
  input  logic               cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [WDATA_W-1:0] cmd_wdata,
  output logic               cmd_busy,
  output logic [RDATA_W-1:0] rsp_data,
  output logic               rsp_valid,
  output logic               pnl_cs_n,
  output logic               pnl_sclk,
  output logic               pnl_sdo,
  input  logic               pnl_sdi
);
  logic run;
  logic tick;

  pfx_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  pfx_seq #(
    .PFX_W      (8),
    .ADDR_W     (ADDR_W),
    .WDATA_W    (WDATA_W),
    .RDATA_W    (RDATA_W),
    .GAP_HALVES (GAP_HALVES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .start    (cmd_start),
    .op       (cmd_op),
    .addr     (cmd_addr),
    .wdata    (cmd_wdata),
    .busy     (cmd_busy),
    .rd_data  (rsp_data),
    .rd_valid (rsp_valid),
    .cs_n     (pnl_cs_n),
    .sclk     (pnl_sclk),
    .sdo      (pnl_sdo),
    .sdi      (pnl_sdi)
  );
endmodule

// File: tb/pfx_reg_engine_tb.sv
module pfx_reg_engine_tb;
  localparam int HALF_DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic        cmd_op = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_busy;
  logic [15:0] rsp_data;
  logic        rsp_valid;
  logic        pnl_cs_n, pnl_sclk, pnl_sdo;
  logic        pnl_sdi = 1'b1;

  always #4 clk = ~clk;

  pfx_reg_engine #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .pnl_cs_n(pnl_cs_n),
    .pnl_sclk(pnl_sclk), .pnl_sdo(pnl_sdo), .pnl_sdi(pnl_sdi)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Panel model and pin monitor
  int          cyc = 0;
  logic        p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b1;
  logic [31:0] fbuf;
  int          fcnt = 0;
  logic [31:0] fr [0:3];
  int          fl [0:3];
  int          nfr = 0;
  int          gap_cur = 0, gap_min = 1000000;
  int          rv_cnt = 0, rv_dly = 0, cs_rise_cyc = 0;
  logic [15:0] rv_data;
  logic [15:0] pnl_word = '0;
  int          bad_sdo = 0, bad_sclk = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !pnl_cs_n) begin
        fbuf = '0; fcnt = 0;
        if (nfr > 0 && gap_cur < gap_min) gap_min = gap_cur;
      end
      if (!pnl_cs_n && !p_sclk && pnl_sclk) begin
        fbuf = {fbuf[30:0], pnl_sdo}; fcnt++;
      end
      if (!pnl_cs_n && p_sclk && !pnl_sclk && fcnt >= 8 && fcnt < 24)
        pnl_sdi = pnl_word[23 - fcnt];
      if (!p_cs && pnl_cs_n) begin
        if (nfr < 4) begin fr[nfr] = fbuf; fl[nfr] = fcnt; end
        nfr++; cs_rise_cyc = cyc; gap_cur = 1; pnl_sdi = 1'b1;
      end else if (pnl_cs_n) gap_cur++;
      if (pnl_sdo != p_sdo && pnl_sclk) bad_sdo++;
      if (pnl_cs_n && pnl_sclk) bad_sclk++;
      if (rsp_valid) begin
        rv_cnt++; rv_data = rsp_data; rv_dly = cyc - cs_rise_cyc;
      end
    end
    p_cs = pnl_cs_n; p_sclk = pnl_sclk; p_sdo = pnl_sdo;
  end

  task automatic issue(input logic op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    nfr = 0; rv_cnt = 0; gap_min = 1000000;
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(cmd_busy === 1'b1, "R10 busy after start", 32'(cmd_busy), 1);
  endtask

  task automatic finish_txn();
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    @(negedge clk);
    chk(pnl_cs_n && pnl_sdo && !pnl_sclk, "R9 parked pins",
        {29'd0, pnl_cs_n, pnl_sdo, pnl_sclk}, 32'h6);
  endtask

  task automatic check_write(input logic [7:0] a, input logic [7:0] d);
    chk(nfr == 2, "R2 frame count", 32'(nfr), 2);
    chk(fl[0] == 16 && fr[0][15:0] == {8'h70, a}, "R2 index frame",
        {fl[0][7:0], 8'h0, fr[0][15:0]}, {8'd16, 8'h0, 8'h70, a});
    chk(fl[1] == 16 && fr[1][15:0] == {8'h72, d}, "R3 data frame",
        {fl[1][7:0], 8'h0, fr[1][15:0]}, {8'd16, 8'h0, 8'h72, d});
    chk(gap_min >= 2 * HALF_DIV, "R4 inter-frame gap", 32'(gap_min), 2 * HALF_DIV);
    chk(rv_cnt == 0, "R7 no valid on write", 32'(rv_cnt), 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    issue(1'b0, a, d);
    finish_txn();
    check_write(a, d);
  endtask

  task automatic do_read(input logic [15:0] w, input logic [7:0] a);
    pnl_word = w;
    issue(1'b1, a, 8'h00);
    finish_txn();
    chk(nfr == 1 && fl[0] == 24, "R5 read frame length", 32'(fl[0]), 24);
    chk(fr[0][23:0] == 24'h73FFFF, "R5 read prefix and high sdo",
        {8'h0, fr[0][23:0]}, 32'h73FFFF);
    chk(rv_cnt == 1 && rv_dly == 1, "R7 valid timing",
        {rv_cnt[15:0], rv_dly[15:0]}, 32'h00010001);
    chk(rv_data == w, "R6 read word", {16'h0, rv_data}, {16'h0, w});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(pnl_cs_n && !pnl_sclk && pnl_sdo && !cmd_busy && !rsp_valid,
        "R1 reset state",
        {27'd0, pnl_cs_n, pnl_sclk, pnl_sdo, cmd_busy, rsp_valid}, 32'h14);

    // R2/R3/R4 write sweep over all addresses
    for (int i = 0; i < 256; i++)
      do_write(8'(i), 8'(i * 37 + 91));

    // R5/R6/R7 read sweep
    for (int i = 0; i < 16; i++) do_read(16'(1 << i), 8'(i));
    for (int i = 0; i < 16; i++) do_read(~16'(1 << i), 8'(i + 16));
    do_read(16'h0000, 8'h40);
    do_read(16'hFFFF, 8'h41);
    do_read(16'hA5C3, 8'h42);
    do_read(16'h1E78, 8'h43);

    // R10 start while busy is ignored
    issue(1'b0, 8'h5A, 8'hC6);
    repeat (10) @(negedge clk);
    cmd_op = 1'b1; cmd_addr = 8'h11; cmd_wdata = 8'h22; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    finish_txn();
    check_write(8'h5A, 8'hC6);
    repeat (200) @(negedge clk);
    chk(nfr == 2 && rv_cnt == 0, "R10 ignored start left no frame",
        {nfr[15:0], rv_cnt[15:0]}, 32'h00020000);

    // R8 edge discipline observed at the pins
    chk(bad_sdo == 0, "R8 sdo moved while sclk high", 32'(bad_sdo), 0);
    chk(bad_sclk == 0, "R8 sclk high while deselected", 32'(bad_sclk), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule